// File: doc/BRIEF.md
# Triplicated Memory with Background Scrubbing

This block is a single-port word memory that keeps three full copies of its contents. Each copy is a dual-port array. The first port of every copy serves the user. Writes go to all three copies at once, and every read returns the bitwise majority of the three words. A single corrupted copy therefore never reaches the read data.

The second port of each copy belongs to a scrubber that never stops and never waits for the user to go quiet. For each address it reads the three copies, votes, and writes the voted word back into every copy that disagrees. It then waits a fixed number of cycles and moves on to the next address. After the last address it wraps back to address zero. A word hit by one upset is repaired before a second upset can land in another copy of the same word. The price is at least three times the storage of an unprotected memory.

The scrubber signals each repair with a one-cycle pulse on a per-copy flag. If the user writes the address that the scrubber is working on, the pending write-back is dropped, so the user's data is always kept.

Top module: `tmr_scrub_mem`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `addr` in all three copies. A read presents `addr` with `wr_en` low, and `rd_data` holds the stored word from the next cycle onward.
- R2: `rd_data` is the per-bit majority of the three copies. A word corrupted in one copy reads back correctly, and so does a word whose copies are corrupted in different bits.
- R3: When two copies share the same flipped bit, that bit reads back flipped.
- R4: A copy that disagrees with the vote is rewritten with the voted word within one scrub pass of DEPTH*(GAP+3) cycles. A later upset in another copy of that word is then masked.
- R5: `fix_pulse[c]` is high for exactly one cycle when copy c is rewritten by the scrubber. It stays low while all copies agree.
- R6: A user write to the address under scrub, made during its read, compare or write-back step, cancels that write-back. No pulse is issued and the user's word remains in all copies.
- R7: The scrub address wraps from DEPTH-1 to 0. The write-back of address 0 follows that of address DEPTH-1 after GAP+3 cycles.
- R8: Each address takes GAP idle cycles plus three steps, so write-backs of addresses k and k+2 lie 2*(GAP+3) cycles apart.
- R9: While `rst_n` is low, `rd_data` and `fix_pulse` are zero.
- R10: A read of an address in the same cycle as a write to it returns the old contents. The new word appears on the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | User write strobe |
| addr | input | AW | User address, for both reads and writes |
| wr_data | input | DW | User write word |
| rd_data | output | DW | Voted read word, one cycle after `addr` |
| fix_pulse | output | 3 | One bit per copy, high for one cycle when the scrubber repairs that copy |

## Verification
The voter is exercised with table words whose corruption masks hit one copy, single bits, whole words and alternating bits. Two further patterns are applied to the same word: disjoint masks in two copies, which only a bitwise vote survives, and one mask shared by two copies, which a correct majority must pass through. Scrub repair is told apart from mere masking by corrupting a second copy after the repair pulse: an unrepaired word would then read wrong. Pulse spacing between corrupted neighbours, including the pair at the top and bottom addresses, separates the interval and wrap logic. A user write timed into a scrub step shows whether cancellation keeps the new word.

// File: rtl/tmr_scrub_mem.sv
module tmr_scrub_mem #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 256,
  parameter  int GAP   = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = (GAP > 1) ? $clog2(GAP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    fix_pulse
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CMP, S_WB} scrub_t;

  function automatic logic [DW-1:0] maj(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                        input logic [DW-1:0] z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  logic [DW-1:0] mem [3][DEPTH];
  logic [DW-1:0] a_q [3];
  logic [DW-1:0] b_q [3];
  logic [DW-1:0] word_q;
  logic [2:0]    fix_q;
  logic [AW-1:0] s_addr;
  logic [CW-1:0] cnt;
  logic          kill_q;
  scrub_t        state;

  logic          hit;
  logic          cancel;
  logic [DW-1:0] b_vote;

  assign hit       = wr_en && (addr == s_addr) && (state != S_IDLE);
  assign cancel    = kill_q || hit;
  assign b_vote    = maj(b_q[0], b_q[1], b_q[2]);
  assign rd_data   = maj(a_q[0], a_q[1], a_q[2]);
  assign fix_pulse = (state == S_WB && !cancel) ? fix_q : 3'b000;

  // storage: port B (scrub) first, port A (user) last so the user wins a collision
  always_ff @(posedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (state == S_RD) b_q[c] <= mem[c][s_addr];
      if (fix_pulse[c]) mem[c][s_addr] <= word_q;
      if (wr_en) mem[c][addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) a_q[c] <= '0;
    end else begin
      for (int c = 0; c < 3; c++) a_q[c] <= mem[c][addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      s_addr <= '0;
      cnt    <= '0;
      kill_q <= 1'b0;
      fix_q  <= '0;
      word_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          kill_q <= 1'b0;
          if (cnt == CW'(GAP - 1)) begin
            cnt   <= '0;
            state <= S_RD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RD: begin
          kill_q <= hit;
          state  <= S_CMP;
        end
        S_CMP: begin
          kill_q <= kill_q | hit;
          word_q <= b_vote;
          fix_q  <= {b_q[2] != b_vote, b_q[1] != b_vote, b_q[0] != b_vote};
          state  <= S_WB;
        end
        default: begin
          kill_q <= 1'b0;
          s_addr <= (s_addr == AW'(DEPTH - 1)) ? '0 : s_addr + 1'b1;
          state  <= S_IDLE;
        end
      endcase
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_chk
    assert_repair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fix_pulse[c] |=> mem[c][$past(s_addr)] == $past(word_q));
    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fix_pulse[c] |=> !fix_pulse[c]);
  end

  assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == s_addr && state != S_IDLE) |=> (state == S_IDLE || fix_pulse == 3'b000));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && s_addr == AW'(DEPTH - 1)) |=> (s_addr == '0));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB) |=> (state == S_IDLE && cnt == '0));

  assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cnt != CW'(GAP - 1)) |=> (state == S_IDLE && $stable(s_addr)));

endmodule

// File: tb/sim_tmr_scrub_mem.sv
`timescale 1ns/1ps
module sim_tmr_scrub_mem;
  localparam int DW = 32, DEPTH = 256, GAP = 2, AW = 8;
  localparam int STEP = GAP + 3;
  localparam int PASS = DEPTH * STEP;

  logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  wire  [DW-1:0] rd_data;
  wire  [2:0]    fix_pulse;

  always #2 clk = ~clk;

  tmr_scrub_mem #(.DW(DW), .DEPTH(DEPTH), .GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .fix_pulse(fix_pulse));

  int checks = 0, errors = 0;

  // {addr, data, corruption mask}; corrupted copy = index mod 3
  localparam logic [71:0] VEC [8] = '{
    {8'h05, 32'hDEADBEEF, 32'h0000_0001}, {8'h11, 32'h0000_0000, 32'hFFFF_FFFF},
    {8'h22, 32'hFFFF_FFFF, 32'h8000_0000}, {8'h33, 32'h5555_5555, 32'hAAAA_AAAA},
    {8'h44, 32'h1357_9BDF, 32'h00FF_0000}, {8'h80, 32'hCAFE_F00D, 32'h0F0F_0F0F},
    {8'hC7, 32'h0000_0001, 32'h0000_0001}, {8'hFE, 32'h7FFF_FFFF, 32'hFFFF_0000}};

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h3C, 8'h5A};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic corrupt(input int c, input logic [7:0] a, input logic [31:0] v);
    u0.mem[c][a] = v;
  endtask

  task automatic wait_fix(input int b, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fix_pulse[b] && n < PASS + 4 * STEP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, pulses;
    repeat (3) @(negedge clk);
    chk("R9 rd_data in reset", rd_data, 32'h0);
    chk("R9 fix_pulse in reset", {29'b0, fix_pulse}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) wr(8'(a), pat(8'(a)));

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], d);
      chk("R1 write then read", d, VEC[i][63:32]);
      corrupt(i % 3, VEC[i][71:64], VEC[i][63:32] ^ VEC[i][31:0]);
      rd(VEC[i][71:64], d);
      chk("R2 one copy corrupted", d, VEC[i][63:32]);
    end

    wr(8'h20, 32'h1234_5678);
    chk("R10 read during write sees old", rd_data, pat(8'h20));
    rd(8'h20, d);
    chk("R10 next read sees new", d, 32'h1234_5678);
    wr(8'h20, pat(8'h20));

    repeat (PASS + 50) @(negedge clk);
    pulses = 0;
    repeat (PASS) begin
      @(negedge clk);
      if (fix_pulse != 3'b000) pulses++;
    end
    chk("R5 no pulse when copies agree", 32'(pulses), 32'd0);

    // R4: repair then second upset
    corrupt(1, 8'd60, ~pat(8'd60));
    wait_fix(1, n);
    chk("R4 repair pulse seen", {31'b0, fix_pulse[1]}, 32'd1);
    @(negedge clk);
    chk("R5 pulse lasts one cycle", {29'b0, fix_pulse}, 32'd0);
    corrupt(0, 8'd60, ~pat(8'd60));
    rd(8'd60, d);
    chk("R4 repaired copy outvotes new upset", d, pat(8'd60));
    wr(8'd60, pat(8'd60));

    // R6: user write cancels write-back of address 101
    corrupt(2, 8'd100, ~pat(8'd100));
    corrupt(0, 8'd101, ~pat(8'd101));
    wait_fix(2, n);
    chk("R6 preceding pulse seen", {31'b0, fix_pulse[2]}, 32'd1);
    repeat (GAP + 1) @(negedge clk);
    pulses = 0;
    wr_en = 1'b1; addr = 8'd101; wr_data = 32'hA1B2_C3D4;
    @(negedge clk);
    if (fix_pulse != 3'b000) pulses++;
    wr_en = 1'b0;
    repeat (2) begin
      @(negedge clk);
      if (fix_pulse != 3'b000) pulses++;
    end
    chk("R6 no pulse after cancel", 32'(pulses), 32'd0);
    rd(8'd101, d);
    chk("R6 user word kept", d, 32'hA1B2_C3D4);
    corrupt(1, 8'd101, ~32'hA1B2_C3D4);
    rd(8'd101, d);
    chk("R6 copy holds user word, not stale vote", d, 32'hA1B2_C3D4);
    wr(8'd101, pat(8'd101));

    // R7: wrap from top address to zero
    corrupt(1, 8'd255, ~pat(8'd255));
    corrupt(2, 8'd0, ~pat(8'd0));
    wait_fix(1, n);
    chk("R7 top address pulse", {31'b0, fix_pulse[1]}, 32'd1);
    n = 0;
    do begin @(negedge clk); n++; end while (!fix_pulse[2] && n < 4 * STEP);
    chk("R7 wrap spacing", 32'(n), 32'(STEP));

    // R8: spacing across two addresses
    corrupt(0, 8'd40, ~pat(8'd40));
    corrupt(1, 8'd42, ~pat(8'd42));
    wait_fix(0, n);
    chk("R8 first pulse", {31'b0, fix_pulse[0]}, 32'd1);
    n = 0;
    do begin @(negedge clk); n++; end while (!fix_pulse[1] && n < 4 * STEP);
    chk("R8 interval spacing", 32'(n), 32'(2 * STEP));

    // R2 bitwise and R3 shared flip
    wr(8'd77, 32'hF0F0_1234);
    corrupt(0, 8'd77, 32'hF0F0_1234 ^ 32'h0000_00FF);
    corrupt(1, 8'd77, 32'hF0F0_1234 ^ 32'hFF00_0000);
    rd(8'd77, d);
    chk("R2 disjoint bits in two copies", d, 32'hF0F0_1234);
    corrupt(0, 8'd77, 32'hF0F0_1234 ^ 32'h0001_0000);
    corrupt(1, 8'd77, 32'hF0F0_1234 ^ 32'h0001_0000);
    rd(8'd77, d);
    chk("R3 shared flip shows", d, 32'hF0F1_1234);
    wr(8'd77, pat(8'd77));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule